// File: doc/BRIEF.md
# Interprocessor and interval-timer interrupt registers

This block holds the shared control word of a four-CPU system controller and four per-CPU interval ignore counters. Software uses the control word to raise and acknowledge interprocessor interrupts, to acknowledge interval-timer interrupts, and to manage a small arbitration field. The same word also carries a fixed revision bit and a few plain read/write bits. A read of the word also returns, in its two lowest bits, the index of the CPU that issues the read.

An interval tick input drives all four counters. On each rising edge of the tick, every counter counts down. Once a counter passes below zero it raises a sticky overflow bit. From then on, every tick sets that CPU's timer-interrupt bit, until software writes the counter again. The block drives per-CPU interprocessor and timer interrupt levels. A present-mask input keeps interrupts away from CPUs that are not installed, while their counters keep running.

Register offsets: the control word is at 0x080. The counters for CPU0 to CPU3 are at 0x380, 0x3C0, 0x700 and 0x740. Writes take effect at the clock edge. Reads are combinational.

Top module: `ipi_tick_csr`

## Requirements
- R1: After reset the control word reads 0x8_0000_0000, with bit 35 as the revision flag. Every read of offset 0x080 returns the stored word ORed with csr_cpu_i in bits 1:0.
- R2: A write clears every stored bit for which the write data has a 1 in mask 0x1000_0FF0. This covers timer bits 7:4, interprocessor bits 11:8 and bit 28.
- R3: A write with data bit 20 set clears stored bits 23:16.
- R4: When write data bit 20 is 0, write data bits 23:20 are write-1-to-set. Bits 19:16 are write-1-to-set only if the stored bits 19:16 are all zero; otherwise they keep their value.
- R5: A 1 in write data bits 15:12 sets the matching stored bit 11:8.
- R6: Bits 43:40 take the write data on every write to 0x080.
- R7: ipi_o[i] equals stored bit i+8 and timer_irq_o[i] equals stored bit i+4, both gated by cpu_present_i[i]. A write can clear a timer bit but can never set one.
- R8: A write to a counter offset stores the low 24 data bits and clears overflow bit 24. A read returns the 25-bit counter value, zero-extended.
- R9: On each rising edge of tick_i, every counter becomes (value-1) mod 2^25, with bit 24 kept if it was already set. For a present CPU whose counter has bit 24 set after the update, the timer bit is set.
- R10: A falling edge of tick_i, or a level held high, leaves the counters and timer bits unchanged.
- R11: For a CPU with cpu_present_i low, both interrupt outputs stay low and a tick does not set its timer bit, but its counter still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Write strobe |
| csr_addr_i | input | 12 | Register offset |
| csr_wdata_i | input | 64 | Write data |
| csr_cpu_i | input | 2 | Index of the accessing CPU |
| csr_rdata_o | output | 64 | Read data for csr_addr_i |
| tick_i | input | 1 | Interval tick level |
| cpu_present_i | input | 4 | Installed-CPU mask |
| ipi_o | output | 4 | Interprocessor interrupt per CPU |
| timer_irq_o | output | 4 | Timer interrupt per CPU |

## Verification
Two situations are hard to reach: a counter that has already overflowed and must keep raising the timer bit on every later tick, and a CPU that is absent while its counter wraps. The stimulus loads the four counters with 0, 1, 2 and 3 and keeps CPU3 absent. Successive ticks then make the counters overflow one after another. This exposes the sticky behaviour, the suppression for the absent CPU, and, once CPU3 is marked present, its delivery on the next tick. The arbitration field is driven through a fixed series of writes that reach both the zero and non-zero cases of bits 19:16.

// File: rtl/ipi_tick_pkg.sv
package ipi_tick_pkg;
  localparam int unsigned NCPU   = 4;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned CNT_W  = 24;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h080;
  localparam logic [ADDR_W-1:0] CNT_ADDR [NCPU] = '{12'h380, 12'h3C0, 12'h700, 12'h740};

  localparam logic [DATA_W-1:0] CTRL_RESET = 64'h0000_0008_0000_0000;
  localparam logic [DATA_W-1:0] W1C_MASK   = 64'h0000_0000_1000_0FF0;
  localparam int unsigned ARB_CLR_BIT = 20;
  localparam int unsigned TMR_LSB     = 4;
  localparam int unsigned IPI_LSB     = 8;
  localparam int unsigned REQ_LSB     = 12;
endpackage

// File: rtl/ipi_tick_ctrl.sv
module ipi_tick_ctrl
  import ipi_tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NCPU-1:0]   tmr_set_i,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i) begin
      ctrl_d = ctrl_d & ~(wdata_i & W1C_MASK);
      if (wdata_i[ARB_CLR_BIT]) begin
        ctrl_d[23:16] = '0;
      end else begin
        ctrl_d[23:20] = ctrl_d[23:20] | wdata_i[23:20];
        if (ctrl_q[19:16] == '0) ctrl_d[19:16] = wdata_i[19:16];
      end
      ctrl_d[IPI_LSB +: NCPU] = ctrl_d[IPI_LSB +: NCPU] | wdata_i[REQ_LSB +: NCPU];
      ctrl_d[43:40] = wdata_i[43:40];
    end
    // tick delivery wins over a same-cycle clear
    ctrl_d[TMR_LSB +: NCPU] = ctrl_d[TMR_LSB +: NCPU] | tmr_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RESET;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  AST_TMR_NO_WRITE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((ctrl_q[TMR_LSB +: NCPU] &
               ~($past(ctrl_q[TMR_LSB +: NCPU]) | $past(tmr_set_i))) == '0)); // R7
  AST_ARB_LOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[ARB_CLR_BIT] && ctrl_q[19:16] != '0) |=> $stable(ctrl_q[19:16])); // R4
  AST_ARB_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[ARB_CLR_BIT]) |=> (ctrl_q[23:16] == '0)); // R3
endmodule

// File: rtl/ipi_tick_cnt.sv
module ipi_tick_cnt
  import ipi_tick_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic           tick_rise_i,
  output logic [CNT_W:0] cnt_o,
  output logic           fire_o
);
  logic [CNT_W:0] cnt_q, dec;

  assign dec = cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (we_i)        cnt_q <= {1'b0, wdata_i};
    else if (tick_rise_i) cnt_q <= {cnt_q[CNT_W] | dec[CNT_W], dec[CNT_W-1:0]};
  end

  // overflow bit is set after this tick's update
  assign fire_o = tick_rise_i && !we_i && (cnt_q[CNT_W] || cnt_q[CNT_W-1:0] == '0);
  assign cnt_o  = cnt_q;

  AST_WRITE_CLEARS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_q == {1'b0, $past(wdata_i)})); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q[CNT_W] && !we_i) |=> cnt_q[CNT_W]); // R9
  AST_NO_EDGE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_rise_i && !we_i) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/ipi_tick_csr.sv
module ipi_tick_csr
  import ipi_tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  input  logic [1:0]        csr_cpu_i,
  output logic [DATA_W-1:0] csr_rdata_o,
  input  logic              tick_i,
  input  logic [NCPU-1:0]   cpu_present_i,
  output logic [NCPU-1:0]   ipi_o,
  output logic [NCPU-1:0]   timer_irq_o
);
  logic              tick_q, tick_rise;
  logic [DATA_W-1:0] ctrl;
  logic [NCPU-1:0]   fire, cnt_hit;
  logic [CNT_W:0]    cnt [NCPU];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_i;
  end
  assign tick_rise = tick_i & ~tick_q;

  ipi_tick_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (csr_we_i && csr_addr_i == CTRL_ADDR),
    .wdata_i   (csr_wdata_i),
    .tmr_set_i (fire & cpu_present_i),
    .ctrl_o    (ctrl)
  );

  for (genvar i = 0; i < NCPU; i++) begin : g_cnt
    assign cnt_hit[i] = (csr_addr_i == CNT_ADDR[i]);
    ipi_tick_cnt u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (csr_we_i && cnt_hit[i]),
      .wdata_i     (csr_wdata_i[CNT_W-1:0]),
      .tick_rise_i (tick_rise),
      .cnt_o       (cnt[i]),
      .fire_o      (fire[i])
    );
  end

  always_comb begin
    csr_rdata_o = '0;
    if (csr_addr_i == CTRL_ADDR) csr_rdata_o = ctrl | {{(DATA_W-2){1'b0}}, csr_cpu_i};
    for (int i = 0; i < NCPU; i++)
      if (cnt_hit[i]) csr_rdata_o = {{(DATA_W-CNT_W-1){1'b0}}, cnt[i]};
  end

  assign ipi_o       = ctrl[IPI_LSB +: NCPU] & cpu_present_i;
  assign timer_irq_o = ctrl[TMR_LSB +: NCPU] & cpu_present_i;

  AST_ABSENT_NO_TMR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && tick_rise) |=>
      ((ctrl[TMR_LSB +: NCPU] & ~$past(ctrl[TMR_LSB +: NCPU]) & ~$past(cpu_present_i)) == '0)); // R11
endmodule

// File: tb/test_ipi_tick_csr.sv
`timescale 1ns/1ps
module test_ipi_tick_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [1:0]  cpu = '0;
  logic [63:0] rdata;
  logic        tick = 1'b0;
  logic [3:0]  present = 4'b0111;
  logic [3:0]  ipi, tmr;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [11:0] CA [4] = '{12'h380, 12'h3C0, 12'h700, 12'h740};

  always #2.5 clk = ~clk;

  ipi_tick_csr i_ipi_tick_csr (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_cpu_i(cpu), .csr_rdata_o(rdata),
    .tick_i(tick), .cpu_present_i(present), .ipi_o(ipi), .timer_irq_o(tmr)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [1:0] c, logic [63:0] exp);
    addr = a; cpu = c; #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic cnts(string tag, logic [24:0] e0, logic [24:0] e1, logic [24:0] e2, logic [24:0] e3);
    rd(tag, CA[0], 0, {39'b0, e0});
    rd(tag, CA[1], 0, {39'b0, e1});
    rd(tag, CA[2], 0, {39'b0, e2});
    rd(tag, CA[3], 0, {39'b0, e3});
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) rd("R1 reset/cpu index", 12'h080, c[1:0], 64'h8_0000_0000 | c);
    chk("R7 reset ipi", {60'b0, ipi}, 0);
    chk("R7 reset timer", {60'b0, tmr}, 0);

    wr(12'h080, 64'hF000);
    rd("R5 request sets ipi", 12'h080, 0, 64'h8_0000_0F00);
    chk("R11 ipi gated by present", {60'b0, ipi}, 64'h7);
    wr(12'h080, 64'h0500);
    rd("R2 ipi clear", 12'h080, 0, 64'h8_0000_0A00);
    chk("R7 ipi follows bits", {60'b0, ipi}, 64'h2);

    wr(12'h080, 64'hA5_0000);
    rd("R4 arb set from zero", 12'h080, 0, 64'h8_00A5_0A00);
    wr(12'h080, 64'h42_0000);
    rd("R4 low arb held when nonzero", 12'h080, 0, 64'h8_00E5_0A00);
    wr(12'h080, 64'h10_0000);
    rd("R3 arb clear", 12'h080, 0, 64'h8_0000_0A00);
    wr(12'h080, 64'h03_0000);
    rd("R4 low arb set after clear", 12'h080, 0, 64'h8_0003_0A00);

    wr(12'h080, 64'hF00_0000_0000);
    rd("R6 rw field set", 12'h080, 2, 64'hF08_0003_0A02);
    wr(12'h080, 64'h500_0000_0000);
    rd("R6 rw field rewrite", 12'h080, 3, 64'h508_0003_0A03);
    wr(12'h080, 64'h1000_0A00);
    rd("R2 clear ipi and bit 28", 12'h080, 0, 64'h8_0003_0000);
    chk("R7 ipi cleared", {60'b0, ipi}, 0);

    wr(CA[0], 64'hFFFF_FFFF);
    rd("R8 low 24 bits kept", CA[0], 1, 64'hFF_FFFF);
    for (int i = 0; i < 4; i++) wr(CA[i], 64'h100_0000 | i);
    cnts("R8 counter load", 0, 1, 2, 3);

    // held-high tick: one decrement only
    @(negedge clk); tick = 1'b1;
    repeat (4) @(negedge clk);
    cnts("R9/R10 tick1 held", 25'h1FF_FFFF, 0, 1, 2);
    chk("R9 tick1 timer", {60'b0, tmr}, 64'h1);
    tick = 1'b0;
    repeat (3) @(negedge clk);
    cnts("R10 falling ignored", 25'h1FF_FFFF, 0, 1, 2);

    pulse();
    cnts("R9 tick2", 25'h1FF_FFFE, 25'h1FF_FFFF, 0, 1);
    chk("R9 tick2 timer", {60'b0, tmr}, 64'h3);
    pulse();
    cnts("R9 tick3", 25'h1FF_FFFD, 25'h1FF_FFFE, 25'h1FF_FFFF, 0);
    chk("R9 tick3 timer", {60'b0, tmr}, 64'h7);
    pulse();
    cnts("R11 absent counter runs", 25'h1FF_FFFC, 25'h1FF_FFFD, 25'h1FF_FFFE, 25'h1FF_FFFF);
    rd("R11 absent timer bit not set", 12'h080, 0, 64'h8_0003_0070);
    chk("R11 absent timer out", {60'b0, tmr}, 64'h7);

    wr(12'h080, 64'h10);
    chk("R2 timer clear cpu0", {60'b0, tmr}, 64'h6);
    wr(12'h080, 64'h60);
    chk("R2 timer clear cpu1/2", {60'b0, tmr}, 64'h0);
    wr(12'h080, 64'h0);
    rd("R7 write cannot set timer", 12'h080, 0, 64'h8_0003_0000);

    wr(CA[0], 64'h5);
    rd("R8 write clears overflow", CA[0], 0, 64'h5);
    pulse();
    cnts("R9 tick5", 25'h4, 25'h1FF_FFFC, 25'h1FF_FFFD, 25'h1FF_FFFE);
    chk("R9 sticky refire", {60'b0, tmr}, 64'h6);
    present = 4'b1111;
    @(negedge clk);
    chk("R11 present no stale timer", {60'b0, tmr}, 64'h6);
    pulse();
    chk("R11 delivery once present", {60'b0, tmr}, 64'hE);
    rd("R9 ctrl after tick6", 12'h080, 1, 64'h8_0003_00E1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule